// File: doc/BRIEF.md
# Configuration Address/Data Decoder

This block is an I/O-port slave that sits in a host bridge and gives software indirect access to device configuration space. It has two port groups. The first is a 32-bit address latch at port 0xCF8 that software loads with an enable flag, a bus number, a combined device/function number and a register number. The second is a four-byte data window at ports 0xCFC through 0xCFF. A data-window access turns into one configuration request on a downstream target port, and the I/O side is stalled until that target answers with a done pulse.

The latch also carries the upper four bits of a 12-bit register offset, so the whole 4 KB of each function can be reached. Byte and word accesses to the data window are steered by their port offset onto the matching lanes of the 32-bit register. A sub-dword write to the latch ports never changes the latch. A byte write to the top latch port sets a one-bit mechanism-select flag instead. When the enable flag is clear, the data window reads as all ones and writes go nowhere.

I/O transfers use a simple hold handshake. The master raises `ioValid` with the address, size, direction and write data. It holds all of them until `ioReady` pulses for one cycle, and then lowers `ioValid`. Sizes are encoded 0 = byte, 1 = word, 2 = dword, and 3 is reserved and treated as unmapped. Read data is right-justified in `ioRdata`.

Top module: `cfg_io_bridge`

## Requirements
- R1: After reset the address latch and the mechanism-select flag are zero, and `ioReady` and `reqValid` are low.
- R2: A dword (size 2) write to port 0xCF8 stores all 32 bits in the latch. A dword read there returns the stored value unchanged, including 0x80000000.
- R3: A request is built from the latch as follows. Bus = latch[23:16]. Device = latch[15:11]. Function = latch[10:8]. The 12-bit register address = {latch[27:24], latch[7:2], 2'b00}, so its low two bits are always zero.
- R4: Byte or word writes to ports 0xCF8 through 0xCFB leave the latch unchanged. A byte write to 0xCFB loads the mechanism-select flag from write-data bit 0. A byte read of 0xCFB returns that flag in bit 0 with zeros above it. Every other sub-dword read of these ports returns all ones.
- R5: A byte access at 0xCFC+n uses byte enable bit n only. On a write, data bits 7:0 go to lane n and the other lanes are zero. On a read, lane n is returned in bits 7:0 with zeros above it.
- R6: A word access at 0xCFC uses byte enables 4'b0011, and one at 0xCFE uses 4'b1100. The selected half is carried in data bits 15:0, with zeros above it on reads and zeros in the unused lanes on writes.
- R7: A dword access at 0xCFC uses byte enables 4'b1111 and carries all 32 data bits.
- R8: While latch bit 31 is clear, a data-window access issues no request. A read returns 0xFFFFFFFF, and a write changes no register.
- R9: A request stays valid with stable fields until the target pulses `reqDone`. `ioReady` pulses for exactly one cycle, in the cycle after the done. An access that makes no request completes with `ioReady` in the cycle after it is accepted.
- R10: A misaligned data-window access (a word at an odd port, a dword at any port but 0xCFC), an access with the reserved size, or an access to any other port issues no request and reads as 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioValid | input | 1 | I/O transfer request, held until ioReady |
| ioWrite | input | 1 | 1 = I/O write, 0 = I/O read |
| ioAddr | input | ADDR_W | I/O port byte address |
| ioSize | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| ioWdata | input | 32 | I/O write data, right-justified |
| ioReady | output | 1 | One-cycle completion pulse |
| ioRdata | output | 32 | I/O read data, valid with ioReady |
| reqValid | output | 1 | Downstream configuration request active |
| reqWrite | output | 1 | Request direction, 1 = write |
| reqBus | output | 8 | Target bus number |
| reqDev | output | 5 | Target device number |
| reqFunc | output | 3 | Target function number |
| reqReg | output | 12 | Dword-aligned register byte address |
| reqBe | output | 4 | Register byte enables |
| reqWdata | output | 32 | Lane-steered write data |
| reqDone | input | 1 | One-cycle completion from the target |
| reqRdata | input | 32 | Register read data, valid with reqDone |

## Verification
The latch is loaded with the detection pattern 0x80000000 and with a dense value whose enable bit is clear. The dense value separates readback from the field decode and shows that every bit is kept. One latch value with distinct nibbles in every field is then used for dword, word and byte traffic through the window. Each lane, the captured byte enables and the target's merged register contents show whether a misplaced lane or a wrong enable pattern occurred. Disabled, misaligned, reserved-size and unmapped accesses are interleaved with a count of downstream requests, which tells a dropped access apart from a silently forwarded one. Target latencies of zero and three cycles show whether completion follows the done pulse or a fixed delay.

// File: rtl/cfg_io_pkg.sv
package cfg_io_pkg;

  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FUNC_W  = 3;
  localparam int REG_W   = 12;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } ioSize_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LATCH = 2'd1,
    ACC_SEL   = 2'd2,
    ACC_DATA  = 2'd3
  } accKind_e;

  typedef struct packed {
    logic latchWr;
    logic selWr;
    logic rdLatch;
    logic rdSel;
    logic rdOnes;
    logic rdRemote;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_io_ctrl.sv
module cfg_io_ctrl
  import cfg_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LATCH_PORT = 'hCF8,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'hCFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic              cfgEnable,
  input  logic              reqDone,
  output dpStrobe_t         strobe,
  output logic              reqValid,
  output logic              ioReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} state_e;

  state_e   state, nextState;
  accKind_e kind;
  logic     latchHit, dataHit;
  logic [1:0] offs;

  assign latchHit = (ioAddr[ADDR_W-1:2] == LATCH_PORT[ADDR_W-1:2]);
  assign dataHit  = (ioAddr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2]);
  assign offs     = ioAddr[1:0];

  // Classify the access by port group, size and alignment.
  always_comb begin
    kind = ACC_NONE;
    if (latchHit) begin
      if (ioSize == SZ_DWORD && offs == 2'd0)     kind = ACC_LATCH;
      else if (ioSize == SZ_BYTE && offs == 2'd3) kind = ACC_SEL;
    end else if (dataHit) begin
      case (ioSize)
        SZ_BYTE:  kind = ACC_DATA;
        SZ_WORD:  kind = offs[0] ? ACC_NONE : ACC_DATA;
        SZ_DWORD: kind = (offs == 2'd0) ? ACC_DATA : ACC_NONE;
        default:  kind = ACC_NONE;
      endcase
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (ioValid) begin
          if (kind == ACC_DATA && cfgEnable) begin
            nextState = ST_WAIT;
          end else begin
            nextState      = ST_DONE;
            strobe.latchWr = ioWrite && (kind == ACC_LATCH);
            strobe.selWr   = ioWrite && (kind == ACC_SEL);
            strobe.rdLatch = !ioWrite && (kind == ACC_LATCH);
            strobe.rdSel   = !ioWrite && (kind == ACC_SEL);
            strobe.rdOnes  = !ioWrite && (kind != ACC_LATCH) && (kind != ACC_SEL);
          end
        end
      end
      ST_WAIT: begin
        if (reqDone) begin
          nextState       = ST_DONE;
          strobe.rdRemote = !ioWrite;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqValid = (state == ST_WAIT);
  assign ioReady  = (state == ST_DONE);

endmodule

// File: rtl/cfg_io_datapath.sv
module cfg_io_datapath
  import cfg_io_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [1:0]        offs,
  input  logic [1:0]        ioSize,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] reqRdata,
  output logic [DATA_W-1:0] addrLatch,
  output logic              mechSel,
  output logic              cfgEnable,
  output logic [DATA_W-1:0] ioRdata,
  output logic [BUS_W-1:0]  reqBus,
  output logic [DEV_W-1:0]  reqDev,
  output logic [FUNC_W-1:0] reqFunc,
  output logic [REG_W-1:0]  reqReg,
  output logic [LANES-1:0]  reqBe,
  output logic [DATA_W-1:0] reqWdata
);

  logic [DATA_W-1:0] rdSteered;

  // Address latch and mechanism-select flag.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLatch <= '0;
      mechSel   <= 1'b0;
    end else begin
      if (strobe.latchWr) addrLatch <= ioWdata;
      if (strobe.selWr)   mechSel   <= ioWdata[0];
    end
  end

  // Field decode of the latch.
  assign cfgEnable = addrLatch[31];
  assign reqBus    = addrLatch[23:16];
  assign reqDev    = addrLatch[15:11];
  assign reqFunc   = addrLatch[10:8];
  assign reqReg    = {addrLatch[27:24], addrLatch[7:2], 2'b00};

  // Per-lane write steering and byte enables.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic laneOn;
    logic [7:0] laneSrc;
    always_comb begin
      laneOn  = 1'b0;
      laneSrc = 8'h00;
      case (ioSize)
        SZ_BYTE: begin
          laneOn  = (offs == 2'(i));
          laneSrc = ioWdata[7:0];
        end
        SZ_WORD: begin
          laneOn  = (offs[1] == 1'(i / 2));
          laneSrc = ioWdata[8*(i%2) +: 8];
        end
        SZ_DWORD: begin
          laneOn  = 1'b1;
          laneSrc = ioWdata[8*i +: 8];
        end
        default: begin
          laneOn  = 1'b0;
          laneSrc = 8'h00;
        end
      endcase
    end
    assign reqBe[i]          = laneOn;
    assign reqWdata[8*i +: 8] = laneOn ? laneSrc : 8'h00;
  end

  // Read steering back to a right-justified value.
  always_comb begin
    case (ioSize)
      SZ_BYTE:  rdSteered = {24'h0, reqRdata[8*offs +: 8]};
      SZ_WORD:  rdSteered = {16'h0, reqRdata[16*offs[1] +: 16]};
      default:  rdSteered = reqRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRdata <= '0;
    end else begin
      if (strobe.rdLatch)  ioRdata <= addrLatch;
      if (strobe.rdSel)    ioRdata <= {{(DATA_W-1){1'b0}}, mechSel};
      if (strobe.rdOnes)   ioRdata <= '1;
      if (strobe.rdRemote) ioRdata <= rdSteered;
    end
  end

endmodule

// File: rtl/cfg_io_bridge.sv
module cfg_io_bridge
  import cfg_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LATCH_PORT = 'hCF8,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'hCFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioValid,
  input  logic              ioWrite,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [1:0]        ioSize,
  input  logic [31:0]       ioWdata,
  output logic              ioReady,
  output logic [31:0]       ioRdata,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [7:0]        reqBus,
  output logic [4:0]        reqDev,
  output logic [2:0]        reqFunc,
  output logic [11:0]       reqReg,
  output logic [3:0]        reqBe,
  output logic [31:0]       reqWdata,
  input  logic              reqDone,
  input  logic [31:0]       reqRdata
);

  dpStrobe_t   strobe;
  logic        cfgEnable;
  logic        mechSel;
  logic [31:0] addrLatch;

  cfg_io_ctrl #(
    .ADDR_W(ADDR_W), .LATCH_PORT(LATCH_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioSize(ioSize), .cfgEnable(cfgEnable),
    .reqDone(reqDone), .strobe(strobe), .reqValid(reqValid),
    .ioReady(ioReady)
  );

  cfg_io_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .offs(ioAddr[1:0]),
    .ioSize(ioSize), .ioWdata(ioWdata), .reqRdata(reqRdata),
    .addrLatch(addrLatch), .mechSel(mechSel), .cfgEnable(cfgEnable),
    .ioRdata(ioRdata), .reqBus(reqBus), .reqDev(reqDev),
    .reqFunc(reqFunc), .reqReg(reqReg), .reqBe(reqBe),
    .reqWdata(reqWdata)
  );

  assign reqWrite = ioWrite;

endmodule

// File: rtl/cfg_io_bridge_chk.sv
module cfg_io_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LATCH_PORT = 'hCF8,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 'hCFC
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioValid,
  input logic              ioWrite,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [1:0]        ioSize,
  input logic              ioReady,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [7:0]        reqBus,
  input logic [11:0]       reqReg,
  input logic [3:0]        reqBe,
  input logic [31:0]       reqWdata,
  input logic              reqDone,
  input logic              cfgEnable,
  input logic [31:0]       addrLatch
);

  // R8: no request while the enable bit is clear
  p_req_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> cfgEnable);

  // R9: request held with stable fields until done
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDone) |=> (reqValid && $stable(reqBus) && $stable(reqReg)
      && $stable(reqBe) && $stable(reqWrite) && $stable(reqWdata)));

  // R9: completion follows done by one cycle
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDone) |=> ioReady);

  // R9: ioReady is a single-cycle pulse
  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ioReady |=> !ioReady);

  // R3: register address dword aligned, at least one lane enabled
  p_reg_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqReg[1:0] == 2'b00 && reqBe != 4'b0000));

  // R4: only a dword write at the latch port can change the latch
  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ioValid && ioWrite && ioAddr == LATCH_PORT && ioSize == 2'd2)
      |=> $stable(addrLatch));

  // R10: an odd word access to the window never produces a request
  p_misaligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ioValid && ioAddr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2]
      && ioSize == 2'd1 && ioAddr[0] && !reqValid) |=> !reqValid);

endmodule

bind cfg_io_bridge cfg_io_bridge_chk #(
  .ADDR_W(ADDR_W), .LATCH_PORT(LATCH_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
  .ioAddr(ioAddr), .ioSize(ioSize), .ioReady(ioReady),
  .reqValid(reqValid), .reqWrite(reqWrite), .reqBus(reqBus),
  .reqReg(reqReg), .reqBe(reqBe), .reqWdata(reqWdata),
  .reqDone(reqDone), .cfgEnable(cfgEnable), .addrLatch(addrLatch)
);

// File: tb/cfg_io_bridge_tb.sv
module cfg_io_bridge_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioValid = 1'b0;
  logic        ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic [31:0] ioWdata = '0;
  logic        ioReady;
  logic [31:0] ioRdata;
  logic        reqValid, reqWrite;
  logic [7:0]  reqBus;
  logic [4:0]  reqDev;
  logic [2:0]  reqFunc;
  logic [11:0] reqReg;
  logic [3:0]  reqBe;
  logic [31:0] reqWdata;
  logic        reqDone = 1'b0;
  logic [31:0] reqRdata = '0;

  int compared = 0;
  int mismatched = 0;
  int latency = 1;
  int reqCount = 0;
  int lastCycles = 0;
  logic [7:0]  lastBus;
  logic [4:0]  lastDev;
  logic [2:0]  lastFunc;
  logic [11:0] lastReg;
  logic [3:0]  lastBe;
  logic [31:0] lastWdata;
  logic        lastWrite;
  logic [31:0] model [16];
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_io_bridge u_dut (
    .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite),
    .ioAddr(ioAddr), .ioSize(ioSize), .ioWdata(ioWdata),
    .ioReady(ioReady), .ioRdata(ioRdata), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqBus(reqBus), .reqDev(reqDev),
    .reqFunc(reqFunc), .reqReg(reqReg), .reqBe(reqBe),
    .reqWdata(reqWdata), .reqDone(reqDone), .reqRdata(reqRdata)
  );

  // Downstream target model: register file keyed by register bits 5:2.
  initial begin
    for (int i = 0; i < 16; i++) model[i] = 32'h0;
    forever begin
      @(negedge clk);
      reqDone = 1'b0;
      if (reqValid) begin
        repeat (latency) @(negedge clk);
        lastBus = reqBus; lastDev = reqDev; lastFunc = reqFunc;
        lastReg = reqReg; lastBe = reqBe; lastWdata = reqWdata;
        lastWrite = reqWrite;
        reqRdata = model[reqReg[5:2]];
        if (reqWrite)
          for (int b = 0; b < 4; b++)
            if (reqBe[b]) model[reqReg[5:2]][8*b +: 8] = reqWdata[8*b +: 8];
        reqCount++;
        reqDone = 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic ioAccess(input logic wr, input logic [15:0] addr,
                          input logic [1:0] size, input logic [31:0] wd,
                          output logic [31:0] rdv);
    int n;
    @(negedge clk);
    ioValid = 1'b1; ioWrite = wr; ioAddr = addr; ioSize = size; ioWdata = wd;
    n = 0;
    rdv = 'x;
    while (n < 50) begin
      @(negedge clk);
      n++;
      if (ioReady) break;
    end
    lastCycles = n;
    rdv = ioRdata;
    ioValid = 1'b0;
  endtask

  task automatic tReset();
    check("R1 ioReady after reset", {31'h0, ioReady}, 32'h0);
    check("R1 reqValid after reset", {31'h0, reqValid}, 32'h0);
    ioAccess(1'b0, 16'hCF8, 2'd2, 32'h0, rd);
    check("R1 latch reset value", rd, 32'h0);
    ioAccess(1'b0, 16'hCFB, 2'd0, 32'h0, rd);
    check("R1 select flag reset value", rd, 32'h0);
  endtask

  task automatic tLatch();
    ioAccess(1'b1, 16'hCF8, 2'd2, 32'h8000_0000, rd);
    ioAccess(1'b0, 16'hCF8, 2'd2, 32'h0, rd);
    check("R2 detect pattern readback", rd, 32'h8000_0000);
    ioAccess(1'b1, 16'hCF8, 2'd2, 32'h7F3C_5D2B, rd);
    ioAccess(1'b0, 16'hCF8, 2'd2, 32'h0, rd);
    check("R2 dense latch readback", rd, 32'h7F3C_5D2B);
    check("R9 local access completes in one cycle", lastCycles, 1);
  endtask

  task automatic tLatchPart();
    ioAccess(1'b1, 16'hCF8, 2'd2, 32'h8A3C_5D28, rd);
    ioAccess(1'b1, 16'hCF8, 2'd0, 32'h0000_00FF, rd);
    ioAccess(1'b1, 16'hCFA, 2'd1, 32'h0000_FFFF, rd);
    ioAccess(1'b1, 16'hCFB, 2'd0, 32'h0000_0001, rd);
    ioAccess(1'b0, 16'hCF8, 2'd2, 32'h0, rd);
    check("R4 latch kept after partial writes", rd, 32'h8A3C_5D28);
    ioAccess(1'b0, 16'hCFB, 2'd0, 32'h0, rd);
    check("R4 select flag set", rd, 32'h1);
    ioAccess(1'b0, 16'hCF8, 2'd1, 32'h0, rd);
    check("R4 word read of latch port", rd, 32'hFFFF_FFFF);
    ioAccess(1'b1, 16'hCFB, 2'd0, 32'h0000_00FE, rd);
    ioAccess(1'b0, 16'hCFB, 2'd0, 32'h0, rd);
    check("R4 select flag cleared by bit 0", rd, 32'h0);
  endtask

  task automatic tDword();
    ioAccess(1'b1, 16'hCFC, 2'd2, 32'h1122_3344, rd);
    check("R3 bus field", lastBus, 32'h3C);
    check("R3 device field", lastDev, 32'h0B);
    check("R3 function field", lastFunc, 32'h5);
    check("R3 register address", lastReg, 32'hA28);
    check("R7 dword enables", lastBe, 32'hF);
    check("R7 dword write data", lastWdata, 32'h1122_3344);
    check("R7 direction write", lastWrite, 32'h1);
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R7 dword readback", rd, 32'h1122_3344);
  endtask

  task automatic tByte();
    ioAccess(1'b0, 16'hCFD, 2'd0, 32'h0, rd);
    check("R5 byte read lane 1", rd, 32'h33);
    check("R5 byte read enables", lastBe, 32'h2);
    ioAccess(1'b1, 16'hCFE, 2'd0, 32'h0000_00AB, rd);
    check("R5 byte write enables", lastBe, 32'h4);
    check("R5 byte write lane 2", lastWdata, 32'h00AB_0000);
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R5 merged after byte write", rd, 32'h11AB_3344);
  endtask

  task automatic tWord();
    ioAccess(1'b0, 16'hCFE, 2'd1, 32'h0, rd);
    check("R6 high word read", rd, 32'h11AB);
    check("R6 high word enables", lastBe, 32'hC);
    ioAccess(1'b1, 16'hCFC, 2'd1, 32'h0000_BEEF, rd);
    check("R6 low word enables", lastBe, 32'h3);
    check("R6 low word write data", lastWdata, 32'h0000_BEEF);
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R6 merged after word write", rd, 32'h11AB_BEEF);
  endtask

  task automatic tDisable();
    int base;
    ioAccess(1'b1, 16'hCF8, 2'd2, 32'h0A3C_5D28, rd);
    base = reqCount;
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R8 disabled read all ones", rd, 32'hFFFF_FFFF);
    ioAccess(1'b1, 16'hCFC, 2'd2, 32'h0, rd);
    check("R8 no request while disabled", reqCount, base);
    ioAccess(1'b1, 16'hCF8, 2'd2, 32'h8A3C_5D28, rd);
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R8 disabled write dropped", rd, 32'h11AB_BEEF);
  endtask

  task automatic tMisaligned();
    int base;
    base = reqCount;
    ioAccess(1'b0, 16'hCFD, 2'd1, 32'h0, rd);
    check("R10 odd word read", rd, 32'hFFFF_FFFF);
    ioAccess(1'b0, 16'hCFE, 2'd2, 32'h0, rd);
    check("R10 offset dword read", rd, 32'hFFFF_FFFF);
    ioAccess(1'b1, 16'hCFC, 2'd3, 32'h0, rd);
    ioAccess(1'b0, 16'h0080, 2'd2, 32'h0, rd);
    check("R10 unmapped port read", rd, 32'hFFFF_FFFF);
    check("R10 no requests issued", reqCount, base);
  endtask

  task automatic tHandshake();
    int base;
    latency = 3;
    base = reqCount;
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R9 completion after slow done", lastCycles, 5);
    check("R9 single request", reqCount, base + 1);
    check("R9 slow read data", rd, 32'h11AB_BEEF);
    latency = 0;
    ioAccess(1'b0, 16'hCFC, 2'd2, 32'h0, rd);
    check("R9 completion after fast done", lastCycles, 2);
    @(negedge clk);
    check("R9 ready dropped after pulse", {31'h0, ioReady}, 32'h0);
    latency = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLatch();
    tLatchPart();
    tDword();
    tByte();
    tWord();
    tDisable();
    tMisaligned();
    tHandshake();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule